// File: doc/BRIEF.md
# Transactional Local-Versioning Metadata Controller

This block holds the transactional status bits of a small first-level data cache and applies the rules that decide how each access, commit and abort changes them. Each line has three flags: it was read in the transaction, it was written in the transaction, or it has been seen as thread-local. Each word has three flags of its own: it was loaded first while local, it was stored while local, and it holds valid data. The data arrays, the tag lookup, the undo buffer storage and the next-level memory sit outside the block. The block tells them what to do through single-cycle, same-cycle request outputs.

An address filter outside the block flags accesses that fall inside the current stack frame or in a thread-local heap page. A local word needs an old-value copy only when it is read before it is written inside the transaction. The block pushes that copy to the undo buffer just before the first such overwrite and never pushes it again. On abort, words that were read locally but never written survive, and every other word is invalidated. On commit, local lines stay valid and shared lines are invalidated. The per-line commit-eligible vector marks the shared lines that the transaction wrote.

Top module: `tx_meta_ctrl`

## Requirements
- R1: After reset every line and word flag is clear, commit_vec_o is all zero, and the first access to any word requests a fill.
- R2: An access is local when req_local_i=1 or when the addressed line's local flag is already set. A local access sets the line's local flag. A non-local load sets the line read flag, and a non-local store (req_store_i=1) sets the line write flag. commit_vec_o[l] is 1 exactly when line l has its write flag set and its local flag clear.
- R3: A local store to an invalid word asserts fill_o in the same cycle. Afterwards the word is valid and its local-store flag is set.
- R4: A local store to a valid word whose local-load flag is set and whose local-store flag is clear asserts undo_push_o in the same cycle.
- R5: A store to a word whose local-store flag is already set never asserts undo_push_o.
- R6: A local load to a valid word asserts neither fill_o nor undo_rd_o. A local load to an invalid word asserts undo_rd_o. If undo_hit_i is also high, fill_o stays low; otherwise fill_o is asserted. The word is valid afterwards. A local load to a word with both local flags clear sets its local-load flag.
- R7: On abort_i, a word stays valid only if its line's local flag is set, its local-load flag is set and its local-store flag is clear. All other words become invalid, and every line and word transactional flag is cleared.
- R8: On commit_i without abort_i, undo_clear_o is asserted in that cycle and all transactional flags are cleared. Words stay valid only in lines whose local flag was set.
- R9: In a cycle with commit_i or abort_i, any access presented is ignored: undo_push_o, undo_rd_o and fill_o stay low and no flag changes because of that access. If both pulses arrive together, abort_i wins.
- R10: An access with req_tag_hit_i=0 treats the addressed word as invalid and clears the valid flags of the other words of that line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | An access is presented this cycle |
| req_store_i | input | 1 | 1 = store, 0 = load |
| req_line_i | input | LINE_W | Line index of the access |
| req_word_i | input | WORD_W | Word index inside the line |
| req_local_i | input | 1 | Address filter marks the access as thread-local |
| req_tag_hit_i | input | 1 | Tag lookup hit for the addressed line |
| undo_hit_i | input | 1 | Undo buffer holds the word requested by undo_rd_o |
| commit_i | input | 1 | Transaction commit pulse |
| abort_i | input | 1 | Transaction abort pulse |
| undo_push_o | output | 1 | Copy the word's current value into the undo buffer before the store |
| undo_rd_o | output | 1 | Look up the undo buffer for the loaded word |
| fill_o | output | 1 | Fetch the word from the next level |
| undo_clear_o | output | 1 | Invalidate all undo buffer entries |
| commit_vec_o | output | NUM_LINES | Lines to include in the commit packet |

## Verification
The hardest situation to reach is the one that makes the undo buffer matter. A word must first be loaded while local and then stored, which triggers the single copy. The transaction must then abort, and the word must be loaded again, so that it comes back through the undo path and not through a fill. A neighbouring word of the same line, loaded but never stored, must survive the same abort. Directed sequences build this on one line. Random traffic over a few lines and words, with local flags, tag misses and undo hits drawn at random and occasional commit and abort pulses, then repeats the read-then-write pattern many times, including on lines that became local only through an earlier access.

// File: rtl/txm_pkg.sv
package txm_pkg;
  // per-access update request for one line
  typedef struct packed {
    logic set_r;
    logic set_w;
    logic set_sl;
    logic set_ll;
    logic set_ls;
    logic set_vld;
    logic drop;
  } meta_upd_t;
endpackage

// File: rtl/txm_access_dec.sv
module txm_access_dec
  import txm_pkg::*;
(
  input  logic      req_valid_i,
  input  logic      req_store_i,
  input  logic      req_local_i,
  input  logic      tag_hit_i,
  input  logic      undo_hit_i,
  input  logic      txn_evt_i,
  input  logic      line_sl_i,
  input  logic      word_ll_i,
  input  logic      word_ls_i,
  input  logic      word_vld_i,
  output logic      undo_push_o,
  output logic      undo_rd_o,
  output logic      fill_o,
  output meta_upd_t upd_o
);
  logic act, loc, vld_eff;

  assign act     = req_valid_i & ~txn_evt_i;
  // a line once seen local stays local for the transaction
  assign loc     = req_local_i | line_sl_i;
  assign vld_eff = word_vld_i & tag_hit_i;

  assign undo_rd_o   = act & loc & ~req_store_i & ~vld_eff;
  assign fill_o      = act & ~vld_eff & (req_store_i | ~loc | ~undo_hit_i);
  assign undo_push_o = act & loc & req_store_i & vld_eff & word_ll_i & ~word_ls_i;

  always_comb begin
    upd_o         = '0;
    upd_o.set_r   = act & ~loc & ~req_store_i;
    upd_o.set_w   = act & ~loc & req_store_i;
    upd_o.set_sl  = act & loc;
    upd_o.set_ll  = act & loc & ~req_store_i & ~word_ll_i & ~word_ls_i;
    upd_o.set_ls  = act & loc & req_store_i;
    upd_o.set_vld = act & ~vld_eff;
    upd_o.drop    = act & ~tag_hit_i;
  end
endmodule

// File: rtl/txm_line_meta.sv
module txm_line_meta
  import txm_pkg::*;
#(
  parameter int unsigned WORDS = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             line_sel_i,
  input  logic [WORDS-1:0] word_sel_i,
  input  meta_upd_t        upd_i,
  input  logic             commit_i,
  input  logic             abort_i,
  output logic             r_o,
  output logic             w_o,
  output logic             sl_o,
  output logic [WORDS-1:0] ll_o,
  output logic [WORDS-1:0] ls_o,
  output logic [WORDS-1:0] vld_o
);
  logic r_q, w_q, sl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      r_q  <= 1'b0;
      w_q  <= 1'b0;
      sl_q <= 1'b0;
    end else if (abort_i || commit_i) begin
      r_q  <= 1'b0;
      w_q  <= 1'b0;
      sl_q <= 1'b0;
    end else if (line_sel_i) begin
      r_q  <= r_q  | upd_i.set_r;
      w_q  <= w_q  | upd_i.set_w;
      sl_q <= sl_q | upd_i.set_sl;
    end
  end

  for (genvar i = 0; i < WORDS; i++) begin : g_word
    logic ll_q, ls_q, vld_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ll_q  <= 1'b0;
        ls_q  <= 1'b0;
        vld_q <= 1'b0;
      end else if (abort_i) begin
        // read-only locals keep their data across abort
        vld_q <= vld_q & sl_q & ll_q & ~ls_q;
        ll_q  <= 1'b0;
        ls_q  <= 1'b0;
      end else if (commit_i) begin
        vld_q <= vld_q & sl_q;
        ll_q  <= 1'b0;
        ls_q  <= 1'b0;
      end else if (line_sel_i) begin
        if (word_sel_i[i]) begin
          ll_q  <= ll_q | upd_i.set_ll;
          ls_q  <= ls_q | upd_i.set_ls;
          vld_q <= vld_q | upd_i.set_vld;
        end else if (upd_i.drop) begin
          vld_q <= 1'b0;
        end
      end
    end

    assign ll_o[i]  = ll_q;
    assign ls_o[i]  = ls_q;
    assign vld_o[i] = vld_q;
  end

  assign r_o  = r_q;
  assign w_o  = w_q;
  assign sl_o = sl_q;
endmodule

// File: rtl/tx_meta_ctrl.sv
module tx_meta_ctrl
  import txm_pkg::*;
#(
  parameter int unsigned NUM_LINES      = 8,
  parameter int unsigned WORDS_PER_LINE = 4,
  localparam int unsigned LINE_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
  localparam int unsigned WORD_W = (WORDS_PER_LINE > 1) ? $clog2(WORDS_PER_LINE) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_valid_i,
  input  logic                 req_store_i,
  input  logic [LINE_W-1:0]    req_line_i,
  input  logic [WORD_W-1:0]    req_word_i,
  input  logic                 req_local_i,
  input  logic                 req_tag_hit_i,
  input  logic                 undo_hit_i,
  input  logic                 commit_i,
  input  logic                 abort_i,
  output logic                 undo_push_o,
  output logic                 undo_rd_o,
  output logic                 fill_o,
  output logic                 undo_clear_o,
  output logic [NUM_LINES-1:0] commit_vec_o
);
  logic [NUM_LINES-1:0]      r_q, w_q, sl_q;
  logic [WORDS_PER_LINE-1:0] ll_q  [NUM_LINES];
  logic [WORDS_PER_LINE-1:0] ls_q  [NUM_LINES];
  logic [WORDS_PER_LINE-1:0] vld_q [NUM_LINES];
  logic [WORDS_PER_LINE-1:0] word_sel;
  logic                      txn_evt;
  logic                      sel_sl, sel_ll, sel_ls, sel_vld;
  meta_upd_t                 upd;

  assign txn_evt  = commit_i | abort_i;
  assign word_sel = WORDS_PER_LINE'(1) << req_word_i;

  assign sel_sl  = sl_q[req_line_i];
  assign sel_ll  = ll_q[req_line_i][req_word_i];
  assign sel_ls  = ls_q[req_line_i][req_word_i];
  assign sel_vld = vld_q[req_line_i][req_word_i];

  txm_access_dec i_dec (
    .req_valid_i (req_valid_i),
    .req_store_i (req_store_i),
    .req_local_i (req_local_i),
    .tag_hit_i   (req_tag_hit_i),
    .undo_hit_i  (undo_hit_i),
    .txn_evt_i   (txn_evt),
    .line_sl_i   (sel_sl),
    .word_ll_i   (sel_ll),
    .word_ls_i   (sel_ls),
    .word_vld_i  (sel_vld),
    .undo_push_o (undo_push_o),
    .undo_rd_o   (undo_rd_o),
    .fill_o      (fill_o),
    .upd_o       (upd)
  );

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    txm_line_meta #(.WORDS(WORDS_PER_LINE)) i_line (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .line_sel_i (req_valid_i && (req_line_i == LINE_W'(l))),
      .word_sel_i (word_sel),
      .upd_i      (upd),
      .commit_i   (commit_i),
      .abort_i    (abort_i),
      .r_o        (r_q[l]),
      .w_o        (w_q[l]),
      .sl_o       (sl_q[l]),
      .ll_o       (ll_q[l]),
      .ls_o       (ls_q[l]),
      .vld_o      (vld_q[l])
    );
    // shared, written lines go to the commit packet
    assign commit_vec_o[l] = w_q[l] & ~sl_q[l];
  end

  assign undo_clear_o = commit_i & ~abort_i;
endmodule

// File: rtl/txm_chk.sv
module txm_chk #(
  parameter int unsigned NUM_LINES = 8,
  parameter int unsigned LINE_W    = 3,
  parameter int unsigned WORD_W    = 2
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 req_valid_i,
  input logic                 req_store_i,
  input logic [LINE_W-1:0]    req_line_i,
  input logic [WORD_W-1:0]    req_word_i,
  input logic                 req_tag_hit_i,
  input logic                 commit_i,
  input logic                 abort_i,
  input logic                 undo_push_o,
  input logic                 undo_rd_o,
  input logic                 fill_o,
  input logic [NUM_LINES-1:0] commit_vec_o
);
  // R9
  evt_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i || abort_i) |-> !(undo_push_o || undo_rd_o || fill_o));

  // R8
  commit_drain_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && !abort_i) |=> (commit_vec_o == '0));

  // R7
  abort_drain_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> (commit_vec_o == '0));

  // R5
  single_push_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(undo_push_o) && !$past(commit_i) && !$past(abort_i) &&
     req_valid_i && req_store_i &&
     $past(req_line_i) == req_line_i && $past(req_word_i) == req_word_i)
    |-> !undo_push_o);

  // R4
  push_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    undo_push_o |-> (req_valid_i && req_store_i && req_tag_hit_i && !fill_o && !undo_rd_o));

  // R6
  undo_rd_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    undo_rd_o |-> (req_valid_i && !req_store_i && !undo_push_o));
endmodule

bind tx_meta_ctrl txm_chk #(
  .NUM_LINES (NUM_LINES),
  .LINE_W    (LINE_W),
  .WORD_W    (WORD_W)
) i_txm_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .req_valid_i   (req_valid_i),
  .req_store_i   (req_store_i),
  .req_line_i    (req_line_i),
  .req_word_i    (req_word_i),
  .req_tag_hit_i (req_tag_hit_i),
  .commit_i      (commit_i),
  .abort_i       (abort_i),
  .undo_push_o   (undo_push_o),
  .undo_rd_o     (undo_rd_o),
  .fill_o        (fill_o),
  .commit_vec_o  (commit_vec_o)
);

// File: tb/test_tx_meta_ctrl.sv
`timescale 1ns/1ps
module test_tx_meta_ctrl;
  localparam int NL = 8;
  localparam int NW = 4;
  localparam int LW = 3;
  localparam int WW = 2;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_valid_i = 1'b0, req_store_i = 1'b0, req_local_i = 1'b0;
  logic          req_tag_hit_i = 1'b1, undo_hit_i = 1'b0, commit_i = 1'b0, abort_i = 1'b0;
  logic [LW-1:0] req_line_i = '0;
  logic [WW-1:0] req_word_i = '0;
  logic          undo_push_o, undo_rd_o, fill_o, undo_clear_o;
  logic [NL-1:0] commit_vec_o;

  int errors = 0;
  int checks = 0;

  // reference state
  bit m_r [NL], m_w [NL], m_sl [NL];
  bit m_ll [NL][NW], m_ls [NL][NW], m_vld [NL][NW];

  always #2 clk = ~clk;

  tx_meta_ctrl #(.NUM_LINES(NL), .WORDS_PER_LINE(NW)) i_tx_meta_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_store_i(req_store_i),
    .req_line_i(req_line_i), .req_word_i(req_word_i), .req_local_i(req_local_i),
    .req_tag_hit_i(req_tag_hit_i), .undo_hit_i(undo_hit_i), .commit_i(commit_i),
    .abort_i(abort_i), .undo_push_o(undo_push_o), .undo_rd_o(undo_rd_o), .fill_o(fill_o),
    .undo_clear_o(undo_clear_o), .commit_vec_o(commit_vec_o)
  );

  function automatic bit [NL-1:0] exp_vec();
    bit [NL-1:0] v;
    for (int l = 0; l < NL; l++) v[l] = m_w[l] & ~m_sl[l];
    return v;
  endfunction

  task automatic chk(input string req, input logic [NL-1:0] act, input logic [NL-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic op(input bit v, input bit st, input int ln, input int wd, input bit lc,
                    input bit hit, input bit uh, input bit cm, input bit ab);
    bit evt, act, loc, veff, e_rd, e_fill, e_push;
    @(negedge clk);
    req_valid_i = v; req_store_i = st; req_line_i = LW'(ln); req_word_i = WW'(wd);
    req_local_i = lc; req_tag_hit_i = hit; undo_hit_i = uh; commit_i = cm; abort_i = ab;
    #1;
    evt   = cm | ab;
    act   = v & ~evt;
    loc   = lc | m_sl[ln];
    veff  = m_vld[ln][wd] & hit;
    e_rd   = act & loc & ~st & ~veff;
    e_fill = act & ~veff & (st | ~loc | ~uh);
    e_push = act & loc & st & veff & m_ll[ln][wd] & ~m_ls[ln][wd];
    chk(evt ? "R9 fill" : "R3/R6 fill", NL'(fill_o), NL'(e_fill));
    chk(evt ? "R9 undo_rd" : "R6 undo_rd", NL'(undo_rd_o), NL'(e_rd));
    chk(evt ? "R9 push" : "R4/R5 push", NL'(undo_push_o), NL'(e_push));
    chk("R8 undo_clear", NL'(undo_clear_o), NL'(cm & ~ab));
    chk("R2 commit_vec", commit_vec_o, exp_vec());
    // model update at the coming edge
    if (ab) begin
      for (int l = 0; l < NL; l++) begin
        for (int w = 0; w < NW; w++) begin
          m_vld[l][w] = m_vld[l][w] & m_sl[l] & m_ll[l][w] & ~m_ls[l][w];
          m_ll[l][w] = 0; m_ls[l][w] = 0;
        end
        m_r[l] = 0; m_w[l] = 0; m_sl[l] = 0;
      end
    end else if (cm) begin
      for (int l = 0; l < NL; l++) begin
        for (int w = 0; w < NW; w++) begin
          m_vld[l][w] = m_vld[l][w] & m_sl[l];
          m_ll[l][w] = 0; m_ls[l][w] = 0;
        end
        m_r[l] = 0; m_w[l] = 0; m_sl[l] = 0;
      end
    end else if (act) begin
      if (!hit) for (int w = 0; w < NW; w++) if (w != wd) m_vld[ln][w] = 0;
      if (loc) begin
        m_sl[ln] = 1;
        if (st) m_ls[ln][wd] = 1;
        else if (!m_ll[ln][wd] && !m_ls[ln][wd]) m_ll[ln][wd] = 1;
      end else if (st) m_w[ln] = 1;
      else m_r[ln] = 1;
      m_vld[ln][wd] = 1;
    end
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R1: reset state, first access fills
    @(negedge clk); #1;
    chk("R1 commit_vec", commit_vec_o, '0);
    op(1, 0, 0, 0, 1, 1, 0, 0, 0);
    // R2: shared writes/reads, commit vector
    op(1, 1, 1, 0, 0, 1, 0, 0, 0);
    op(1, 0, 2, 1, 0, 1, 0, 0, 0);
    op(1, 1, 3, 2, 0, 1, 0, 0, 0);
    op(0, 0, 0, 0, 0, 1, 0, 0, 0);
    // R2: local access turns line 3 local, vector bit drops
    op(1, 0, 3, 3, 1, 1, 0, 0, 0);
    op(1, 1, 3, 2, 0, 1, 0, 0, 0);
    // R3: local store to invalid word fills
    op(1, 1, 4, 0, 1, 1, 0, 0, 0);
    // R6/R4/R5: load first, then store pushes once
    op(1, 0, 5, 1, 1, 1, 0, 0, 0);
    op(1, 0, 5, 1, 1, 1, 0, 0, 0);
    op(1, 1, 5, 1, 1, 1, 0, 0, 0);
    op(1, 1, 5, 1, 1, 1, 0, 0, 0);
    op(1, 0, 5, 1, 1, 1, 0, 0, 0);
    // R7: read-only local word 2 survives abort, word 1 is refetched via undo
    op(1, 0, 5, 2, 1, 1, 0, 0, 0);
    op(1, 0, 5, 0, 1, 1, 0, 1, 1); // R9: abort wins over commit, access ignored
    op(1, 0, 5, 2, 1, 1, 0, 0, 0);
    op(1, 0, 5, 1, 1, 1, 1, 0, 0);
    op(1, 0, 5, 3, 1, 1, 0, 0, 0);
    // R8: commit keeps local lines, drops shared
    op(1, 1, 6, 0, 0, 1, 0, 0, 0);
    op(1, 0, 6, 0, 0, 1, 0, 1, 0);
    op(1, 0, 6, 0, 0, 1, 0, 0, 0);
    op(1, 0, 5, 1, 1, 1, 0, 0, 0);
    // R10: tag miss drops other words of the line
    op(1, 0, 5, 0, 1, 0, 0, 0, 0);
    op(1, 0, 5, 1, 1, 1, 0, 0, 0);
    // random traffic
    for (int n = 0; n < 4000; n++) begin
      int k;
      k = $urandom_range(0, 99);
      op(k < 90, $urandom_range(0, 1), $urandom_range(0, 3), $urandom_range(0, NW - 1),
         $urandom_range(0, 2) != 0, $urandom_range(0, 9) != 0, $urandom_range(0, 1),
         k >= 95, (k >= 91 && k < 95) || k == 99);
    end
    op(0, 0, 0, 0, 0, 1, 0, 0, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule